// File: doc/BRIEF.md
# DRAM Refresh Cycle Decoder

This block belongs to the synchronous model of a multiport DRAM's control logic. On every clock it samples the active-low row strobe, the two byte-lane column strobes, the transfer/output-enable strobe and the write strobe. It then decides what kind of cycle each falling row strobe starts. There are four kinds: a CAS-before-RAS refresh, a hidden refresh that runs alongside a held read, a row-only refresh, or a row-only cycle that becomes a normal access once a column strobe falls.

For every row-strobe fall the block issues a one-cycle refresh request with the row to refresh. For a CAS-before-RAS or hidden refresh, that row comes from an internal 9-bit counter covering 512 rows. For a row-only cycle, it is the externally supplied row address. A 2-bit sideband input selects between three CAS-before-RAS flavours. Only the resetting flavour clears the persistent write-per-bit and stop-point mode flags. The output buffers are reported as high impedance for the whole of a CAS-before-RAS refresh, whatever the transfer strobe does.

Top module: `rfsh_cycle_decoder`

## Requirements
- R1: After reset, refresh_req=0, refresh_row=0, cyc_kind=0 (none), out_hiz=1, wpb_flag=0 and stop_flag=0. The first internally sourced refresh row is 0.
- R2: A row-strobe fall is classified as CAS-before-RAS (cyc_kind=3) when either column strobe was sampled low on the clock before the fall was sampled, and no hidden refresh is armed. refresh_row then carries the internal counter and ignores row_addr.
- R3: The internal counter is 9 bits wide. It advances by one after each CAS-before-RAS or hidden refresh and wraps from 511 to 0.
- R4: A CAS-before-RAS refresh with rfsh_type=00 clears both wpb_flag and stop_flag on the edge at which refresh_req rises.
- R5: A CAS-before-RAS refresh with rfsh_type 01, 10 or 11, and any hidden refresh, leave wpb_flag and stop_flag unchanged.
- R6: A hidden refresh (cyc_kind=4) is taken when two conditions hold. First, the row strobe rose at the end of a read access (write strobe high when the column strobe fell) or of a hidden refresh, with both column strobes low. Second, both column strobes stayed low until the next row-strobe fall. The hidden refresh uses the internal counter and does not force out_hiz. After a write access the same sequence is a CAS-before-RAS refresh.
- R7: A row-strobe fall with both column strobes high on the previous clock gives cyc_kind=1 (row-only). refresh_row then equals row_addr as sampled at the fall, and the counter does not change.
- R8: During a row-only cycle, the first sampled low on either column strobe while the row strobe is low changes cyc_kind to 2 (access) one clock later.
- R9: out_hiz is 1 from the clock after a CAS-before-RAS fall until the clock after the row strobe is sampled high again, regardless of trg_n. At all other times out_hiz follows trg_n delayed by one clock.
- R10: refresh_req is high for exactly one clock. It appears on the clock after the row-strobe fall is sampled, together with the new refresh_row and cyc_kind.
- R11: A high on set_wpb or set_stop sets the matching flag one clock later. A resetting refresh on the same edge takes priority and clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| casl_n | input | 1 | Lower byte-lane column strobe, active low |
| casu_n | input | 1 | Upper byte-lane column strobe, active low |
| trg_n | input | 1 | Transfer/output-enable strobe, active low |
| we_n | input | 1 | Write strobe, active low (high means read) |
| row_addr | input | 9 | External row address |
| rfsh_type | input | 2 | Refresh flavour: 00 resetting, 01/10/11 non-resetting |
| set_wpb | input | 1 | Sets the persistent write-per-bit flag |
| set_stop | input | 1 | Sets the stop-point mode flag |
| refresh_req | output | 1 | One-cycle refresh request |
| refresh_row | output | 9 | Row to refresh |
| cyc_kind | output | 3 | 0 none, 1 row-only, 2 access, 3 CAS-before-RAS, 4 hidden |
| out_hiz | output | 1 | Output buffers held in high impedance |
| wpb_flag | output | 1 | Persistent write-per-bit mode flag |
| stop_flag | output | 1 | Stop-point mode flag |

## Verification
Every strobe passes through one sampling register. The column-strobe order is judged on the clock before the row-strobe fall. refresh_req, refresh_row, cyc_kind and the flag clear are due one clock after the row-strobe low is first sampled. The access upgrade and the out_hiz release are due one clock after the column-strobe fall or the row-strobe rise. The bench drives every input on the falling clock edge and reads outputs on the next falling edge, so each check lands exactly one register stage after its stimulus. It also checks at the following edge that the request has already dropped.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [2:0] {
    K_NONE     = 3'd0,
    K_ROW_ONLY = 3'd1,
    K_ACCESS   = 3'd2,
    K_CBR      = 3'd3,
    K_HIDDEN   = 3'd4
  } kind_t;

  typedef enum logic [1:0] {
    RT_RESET  = 2'd0,
    RT_KEEP_N = 2'd1,
    RT_KEEP_S = 2'd2,
    RT_SPARE  = 2'd3
  } rtype_t;

  function automatic logic clears_modes(input logic [1:0] ty);
    return ty == RT_RESET;
  endfunction

  function automatic logic uses_internal_row(input kind_t k);
    return (k == K_CBR) || (k == K_HIDDEN);
  endfunction
endpackage

// File: rtl/rfsh_strobe_sampler.sv
module rfsh_strobe_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  input  logic casl_n,
  input  logic casu_n,
  input  logic trg_n,
  output logic ras_fall,
  output logic ras_rise,
  output logic cas_prev_any_low,
  output logic cas_now_any_low,
  output logic cas_now_both_low,
  output logic trg_q
);
  logic ras_q, casl_q, casu_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q  <= 1'b1;
      casl_q <= 1'b1;
      casu_q <= 1'b1;
      trg_q  <= 1'b1;
    end else begin
      ras_q  <= ras_n;
      casl_q <= casl_n;
      casu_q <= casu_n;
      trg_q  <= trg_n;
    end
  end

  assign ras_fall         = ras_q & ~ras_n;
  assign ras_rise         = ~ras_q & ras_n;
  assign cas_prev_any_low = ~casl_q | ~casu_q;
  assign cas_now_any_low  = ~casl_n | ~casu_n;
  assign cas_now_both_low = ~casl_n & ~casu_n;
endmodule

// File: rtl/rfsh_classifier.sv
module rfsh_classifier
  import rfsh_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ras_n,
  input  logic  we_n,
  input  logic  ras_fall,
  input  logic  ras_rise,
  input  logic  cas_prev_any_low,
  input  logic  cas_now_any_low,
  input  logic  cas_now_both_low,
  output kind_t cls_now,
  output kind_t kind_q,
  output logic  cbr_active
);
  logic hid_arm, rd_q, arm_cond;

  always_comb begin
    if (hid_arm && cas_now_both_low)  cls_now = K_HIDDEN;
    else if (cas_prev_any_low)        cls_now = K_CBR;
    else                              cls_now = K_ROW_ONLY;
  end

  assign arm_cond = cas_now_both_low &&
                    (((kind_q == K_ACCESS) && rd_q) || (kind_q == K_HIDDEN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q     <= K_NONE;
      cbr_active <= 1'b0;
      hid_arm    <= 1'b0;
      rd_q       <= 1'b0;
    end else if (ras_fall) begin
      kind_q     <= cls_now;
      cbr_active <= (cls_now == K_CBR);
      hid_arm    <= 1'b0;
      rd_q       <= 1'b0;
    end else if (ras_rise) begin
      cbr_active <= 1'b0;
      hid_arm    <= arm_cond;
    end else begin
      if (!cas_now_both_low) hid_arm <= 1'b0;
      if (!ras_n && (kind_q == K_ROW_ONLY) && cas_now_any_low) begin
        kind_q <= K_ACCESS;
        rd_q   <= we_n;
      end
    end
  end
endmodule

// File: rtl/rfsh_row_counter.sv
module rfsh_row_counter #(
  parameter int NUM_ROWS = 512,
  parameter int ROW_W    = $clog2(NUM_ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [ROW_W-1:0] ctr
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

  function automatic logic [ROW_W-1:0] next_row(input logic [ROW_W-1:0] cur);
    return (cur == LAST_ROW) ? '0 : ROW_W'(cur + 1'b1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       ctr <= '0;
    else if (advance) ctr <= next_row(ctr);
  end
endmodule

// File: rtl/rfsh_mode_flags.sv
module rfsh_mode_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_all,
  input  logic set_wpb,
  input  logic set_stop,
  output logic wpb_flag,
  output logic stop_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear_all) begin
      wpb_flag  <= 1'b0;
      stop_flag <= 1'b0;
    end else begin
      wpb_flag  <= wpb_flag  | set_wpb;
      stop_flag <= stop_flag | set_stop;
    end
  end
endmodule

// File: rtl/rfsh_cycle_decoder.sv
module rfsh_cycle_decoder
  import rfsh_pkg::*;
#(
  parameter int NUM_ROWS = 512,
  parameter int ROW_W    = $clog2(NUM_ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             casl_n,
  input  logic             casu_n,
  input  logic             trg_n,
  input  logic             we_n,
  input  logic [ROW_W-1:0] row_addr,
  input  logic [1:0]       rfsh_type,
  input  logic             set_wpb,
  input  logic             set_stop,
  output logic             refresh_req,
  output logic [ROW_W-1:0] refresh_row,
  output logic [2:0]       cyc_kind,
  output logic             out_hiz,
  output logic             wpb_flag,
  output logic             stop_flag
);
  logic ras_fall, ras_rise, cas_prev_any_low, cas_now_any_low, cas_now_both_low;
  logic trg_q, cbr_active, ctr_advance, clear_modes;
  kind_t cls_now, kind_q;
  logic [ROW_W-1:0] int_ctr;

  rfsh_strobe_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .casl_n(casl_n), .casu_n(casu_n),
    .trg_n(trg_n), .ras_fall(ras_fall), .ras_rise(ras_rise),
    .cas_prev_any_low(cas_prev_any_low), .cas_now_any_low(cas_now_any_low),
    .cas_now_both_low(cas_now_both_low), .trg_q(trg_q)
  );

  rfsh_classifier u_cls (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .we_n(we_n),
    .ras_fall(ras_fall), .ras_rise(ras_rise),
    .cas_prev_any_low(cas_prev_any_low), .cas_now_any_low(cas_now_any_low),
    .cas_now_both_low(cas_now_both_low), .cls_now(cls_now), .kind_q(kind_q),
    .cbr_active(cbr_active)
  );

  assign ctr_advance = ras_fall && uses_internal_row(cls_now);
  assign clear_modes = ras_fall && (cls_now == K_CBR) && clears_modes(rfsh_type);

  rfsh_row_counter #(.NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .advance(ctr_advance), .ctr(int_ctr)
  );

  rfsh_mode_flags u_flags (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_modes),
    .set_wpb(set_wpb), .set_stop(set_stop),
    .wpb_flag(wpb_flag), .stop_flag(stop_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      refresh_req <= 1'b0;
      refresh_row <= '0;
    end else begin
      refresh_req <= ras_fall;
      if (ras_fall) refresh_row <= uses_internal_row(cls_now) ? int_ctr : row_addr;
    end
  end

  assign cyc_kind = kind_q;
  assign out_hiz  = cbr_active | trg_q;
endmodule

// File: rtl/rfsh_cycle_decoder_chk.sv
module rfsh_cycle_decoder_chk #(
  parameter int NUM_ROWS = 512,
  parameter int ROW_W    = $clog2(NUM_ROWS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ROW_W-1:0] row_addr,
  input logic [1:0]       rfsh_type,
  input logic             set_wpb,
  input logic             set_stop,
  input logic             refresh_req,
  input logic [ROW_W-1:0] refresh_row,
  input logic [2:0]       cyc_kind,
  input logic             out_hiz,
  input logic             wpb_flag,
  input logic             stop_flag,
  input logic [ROW_W-1:0] ctr
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |=> !refresh_req); // R10

  AST_ROW_ONLY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && cyc_kind == 3'd1) |-> (refresh_row == $past(row_addr) && $stable(ctr))); // R7

  AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && (cyc_kind == 3'd3 || cyc_kind == 3'd4)) |->
      (ctr == ((refresh_row == LAST_ROW) ? '0 : ROW_W'(refresh_row + 1'b1)))); // R3

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && cyc_kind == 3'd3 && $past(rfsh_type) == 2'd0) |-> (!wpb_flag && !stop_flag)); // R4

  AST_KEEP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && (cyc_kind == 3'd4 || (cyc_kind == 3'd3 && $past(rfsh_type) != 2'd0))) |->
      (wpb_flag == ($past(wpb_flag) | $past(set_wpb)) &&
       stop_flag == ($past(stop_flag) | $past(set_stop)))); // R5

  AST_CBR_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && cyc_kind == 3'd3) |-> out_hiz); // R9

  AST_HIDDEN_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && cyc_kind == 3'd4) |-> (refresh_row == $past(ctr))); // R6
endmodule

bind rfsh_cycle_decoder rfsh_cycle_decoder_chk #(.NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .row_addr(row_addr), .rfsh_type(rfsh_type),
  .set_wpb(set_wpb), .set_stop(set_stop), .refresh_req(refresh_req),
  .refresh_row(refresh_row), .cyc_kind(cyc_kind), .out_hiz(out_hiz),
  .wpb_flag(wpb_flag), .stop_flag(stop_flag), .ctr(int_ctr)
);

// File: tb/rfsh_cycle_decoder_tb.sv
module rfsh_cycle_decoder_tb;
  logic clk = 1'b0;
  logic rst_n, ras_n, casl_n, casu_n, trg_n, we_n, set_wpb, set_stop;
  logic [8:0] row_addr;
  logic [1:0] rfsh_type;
  logic refresh_req, out_hiz, wpb_flag, stop_flag;
  logic [8:0] refresh_row;
  logic [2:0] cyc_kind;
  int checks = 0, errors = 0;
  int exp_ctr = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rfsh_cycle_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .casl_n(casl_n), .casu_n(casu_n),
    .trg_n(trg_n), .we_n(we_n), .row_addr(row_addr), .rfsh_type(rfsh_type),
    .set_wpb(set_wpb), .set_stop(set_stop), .refresh_req(refresh_req),
    .refresh_row(refresh_row), .cyc_kind(cyc_kind), .out_hiz(out_hiz),
    .wpb_flag(wpb_flag), .stop_flag(stop_flag)
  );

  task automatic step(); @(negedge clk); endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    ras_n = 1; casl_n = 1; casu_n = 1; we_n = 1;
    set_wpb = 0; set_stop = 0; rfsh_type = 2'd0; row_addr = 9'd0;
  endtask

  task automatic t_reset();
    idle_bus(); trg_n = 1; rst_n = 0;
    step(); step(); rst_n = 1; step();
    check("R1 req", refresh_req, 0);
    check("R1 row", refresh_row, 0);
    check("R1 kind", cyc_kind, 0);
    check("R1 hiz", out_hiz, 1);
    check("R1 flags", {wpb_flag, stop_flag}, 0);
    exp_ctr = 0;
  endtask

  // CBR cycle; lanes: 1 lower, 2 upper, 3 both
  task automatic cbr(input logic [1:0] ty, input int lanes, input bit full);
    casl_n = !(lanes & 1); casu_n = !(lanes & 2); row_addr = 9'h155; rfsh_type = ty;
    step();
    ras_n = 0; step();
    if (full) begin
      check("R2 kind", cyc_kind, 3);
      check("R10 req", refresh_req, 1);
      check("R9 hiz during CBR", out_hiz, 1);
    end
    check("R2/R3 internal row", refresh_row, exp_ctr);
    exp_ctr = (exp_ctr + 1) % 512;
    step();
    if (full) begin
      check("R10 req drops", refresh_req, 0);
      check("R9 hiz held", out_hiz, 1);
    end
    ras_n = 1; casl_n = 1; casu_n = 1; step();
  endtask

  task automatic t_row_only_access();
    trg_n = 0; row_addr = 9'h0A7; step();
    ras_n = 0; step();
    check("R7 kind", cyc_kind, 1);
    check("R7 row", refresh_row, 9'h0A7);
    check("R10 req", refresh_req, 1);
    row_addr = 9'h1FF; step();
    check("R10 pulse", refresh_req, 0);
    check("R7 row held", refresh_row, 9'h0A7);
    check("R9 hiz follows trg", out_hiz, 0);
    casu_n = 0; step();
    check("R8 access", cyc_kind, 2);
    ras_n = 1; casu_n = 1; step();
    ras_n = 0; row_addr = 9'h003; step();
    check("R7 ctr unchanged", refresh_row, 9'h003);
    ras_n = 1; step();
    cbr(2'd1, 3, 1); // internal row shows counter untouched by row-only cycles
  endtask

  task automatic t_cbr_flags();
    trg_n = 0;
    set_wpb = 1; set_stop = 1; step(); set_wpb = 0; set_stop = 0;
    check("R11 set", {wpb_flag, stop_flag}, 3);
    cbr(2'd1, 1, 1); check("R5 type01", {wpb_flag, stop_flag}, 3);
    cbr(2'd2, 2, 1); check("R5 type10", {wpb_flag, stop_flag}, 3);
    cbr(2'd3, 3, 1); check("R5 type11", {wpb_flag, stop_flag}, 3);
    check("R9 hiz released", out_hiz, 0);
    cbr(2'd0, 1, 1); check("R4 cleared", {wpb_flag, stop_flag}, 0);
    set_wpb = 1; step(); set_wpb = 0;
    check("R11 wpb only", {wpb_flag, stop_flag}, 2);
    // clear wins over a simultaneous set
    casl_n = 0; rfsh_type = 2'd0; step();
    ras_n = 0; set_stop = 1; set_wpb = 1; step(); set_stop = 0; set_wpb = 0;
    check("R11 clear wins", {wpb_flag, stop_flag}, 0);
    check("R4 row", refresh_row, exp_ctr);
    exp_ctr = (exp_ctr + 1) % 512;
    ras_n = 1; casl_n = 1; step(); step();
  endtask

  task automatic t_hidden();
    trg_n = 0; set_wpb = 1; step(); set_wpb = 0;
    row_addr = 9'h010; ras_n = 0; step();
    casl_n = 0; casu_n = 0; we_n = 1; step();
    check("R8 read access", cyc_kind, 2);
    ras_n = 1; step();
    ras_n = 0; row_addr = 9'h1AA; step();
    check("R6 hidden kind", cyc_kind, 4);
    check("R6 internal row", refresh_row, exp_ctr);
    check("R6 no forced hiz", out_hiz, 0);
    check("R5 hidden keeps", {wpb_flag, stop_flag}, 2);
    exp_ctr = (exp_ctr + 1) % 512;
    ras_n = 1; step();
    ras_n = 0; step();
    check("R6 repeated hidden", cyc_kind, 4);
    check("R3 advance", refresh_row, exp_ctr);
    exp_ctr = (exp_ctr + 1) % 512;
    ras_n = 1; casl_n = 1; casu_n = 1; step(); step();
    // write access followed by held strobes gives CBR instead
    ras_n = 0; step();
    casl_n = 0; casu_n = 0; we_n = 0; step();
    ras_n = 1; we_n = 1; step();
    ras_n = 0; step();
    check("R6 after write is CBR", cyc_kind, 3);
    check("R2 row", refresh_row, exp_ctr);
    exp_ctr = (exp_ctr + 1) % 512;
    ras_n = 1; casl_n = 1; casu_n = 1; step(); step();
  endtask

  task automatic t_wrap();
    while (exp_ctr != 511) cbr(2'd1, 1, 0);
    casl_n = 0; step(); ras_n = 0; step();
    check("R3 last row", refresh_row, 511);
    ras_n = 1; casl_n = 1; step(); step();
    casl_n = 0; step(); ras_n = 0; step();
    check("R3 wrap", refresh_row, 0);
    exp_ctr = 1;
    ras_n = 1; casl_n = 1; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_row_only_access();
    t_cbr_flags();
    t_hidden();
    t_wrap();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule